// File: doc/BRIEF.md
# BCD calendar clock with alarm

This block keeps the wall-clock time and the date as packed BCD bytes: seconds, minutes and hours in a 24-bit time word, day, month and a two-digit year in a 24-bit date word, plus a 3-bit weekday count. A one-second strobe advances the clock. Software loads every field through a single write port: a 3-bit register select, a write enable and a 24-bit data word. Loads take effect on the next clock edge. The hour runs either in 24-hour form or in a 12-hour form. In the 12-hour form the PM hours are stored as BCD 21 to 32, and no separate AM/PM bit exists.

Each accepted second strobe starts a short update sequence in a four-state machine. IDLE goes to STEP_TIME when a strobe arrives. STEP_TIME advances the time word, then goes to STEP_DATE when the hour wraps past the end of the day, and otherwise goes to COMPARE. STEP_DATE advances the day, month, year and weekday, then goes to COMPARE. COMPARE checks the time and date against the alarm words, then returns to IDLE. Any second strobe that arrives outside IDLE is dropped.

A separate periodic tick input sets a tick flag when its enable is set. An alarm match sets an alarm flag when its enable is set. Either event produces a one-cycle wake pulse when the wake enable is set. A leap-year indicator follows the stored year.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time word reads 0x000000, the date word reads 0x000101 (year 00, month 01, day 01), the weekday reads 6, both flags read 0 and the wake output reads 0.
- R2: A second strobe accepted in IDLE changes the time word two clock edges later. Seconds step in BCD and wrap from 59 to 00 with a carry into minutes. Minutes wrap from 59 to 00 with a carry into hours. Outside an update step and a time load, the time word holds.
- R3: With the format set to 24-hour, the hour steps in BCD from 00 to 23. The step from 23 wraps to 00 and advances the date by one day.
- R4: With the format set to 12-hour, the hour byte follows the order 12, 01, 02, ..., 11, 32, 21, 22, ..., 31, 12. Here 0x01–0x12 mean AM01–AM12 and 0x21–0x32 mean PM01–PM12. Only the step 0x31→0x12 advances the date.
- R5: On a day advance, the day wraps to 01 with a month step when it passes the last day of its month. Months 04, 06, 09 and 11 have 30 days. February has 29 days in a leap year and 28 otherwise. All other months have 31 days. Month 12 wraps to 01 with a year step. Year 99 wraps to 00.
- R6: Each day advance steps the weekday by one and wraps it from 6 to 0.
- R7: The leap output is 1 exactly when the BCD year value is divisible by 4. Year 00 counts as a leap year.
- R8: In COMPARE, when the time word and the date word both equal the alarm words and the alarm enable is 1, the alarm flag becomes 1 on that edge. The flag never sets with the enable at 0 or on a mismatch.
- R9: A tick strobe with the tick enable at 1 sets the tick flag on the next edge. With the enable at 0 the tick strobe leaves the flag unchanged.
- R10: Writing select 7 clears the alarm flag when data bit 0 is 1 and clears the tick flag when data bit 1 is 1. A 0 bit leaves its flag alone. A set in the same cycle wins over the clear.
- R11: With the wake enable at 1, a tick strobe or an alarm match in COMPARE produces a wake pulse one cycle wide on the next edge. This happens whatever the interrupt enables are. With the wake enable at 0 no pulse appears.
- R12: The write selects are: 0 time word, 1 date word, 2 weekday, 3 format (bit 0: 1 = 24-hour, 0 = 12-hour; reset 24-hour), 4 alarm time word, 5 alarm date word, 6 enables (bit 0 alarm, bit 1 tick, bit 2 wake), 7 flag clear. A time or date load shows on the next edge. Bits outside the fields read as zero: the time mask is 0x3F7F7F and the date mask is 0xFF1F3F.
- R13: A second strobe that arrives while an update sequence is in progress is ignored. A strobe held for two cycles advances the seconds by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_stb | input | 1 | One-second advance strobe |
| tick_stb | input | 1 | Periodic tick strobe |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 3 | Register select (see R12) |
| wr_data | input | 24 | Write data |
| time_o | output | 24 | Current time word, hours/minutes/seconds in BCD |
| date_o | output | 24 | Current date word, year/month/day in BCD |
| dow_o | output | 3 | Weekday count, 0 to 6 |
| leap_o | output | 1 | Current year is a leap year |
| alarm_flag_o | output | 1 | Alarm interrupt flag |
| tick_flag_o | output | 1 | Tick interrupt flag |
| wake_o | output | 1 | One-cycle wake-up pulse |

## Verification
Timing is counted from the edge that samples a second strobe in IDLE. The time word changes on the second edge after it and the date and weekday on the third. The alarm flag and wake pulse appear on the third edge, or on the fourth when the date rolls. Loads, the leap output, tick-driven flags and tick wake pulses settle one edge after their write or strobe. The bench samples at the falling edge. For each advance it waits six falling edges, which is past every due cycle. Flag and wake checks sample at the exact falling edge after the due edge, so that the one-cycle width of the wake pulse is also checked.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int WORD_W = 24;
    localparam int SEL_W  = 3;

    // Field masks for the packed BCD words
    localparam logic [WORD_W-1:0] TIME_MASK = 24'h3F7F7F;
    localparam logic [WORD_W-1:0] DATE_MASK = 24'hFF1F3F;

    typedef enum logic [SEL_W-1:0] {
        SEL_TIME     = 3'd0,
        SEL_DATE     = 3'd1,
        SEL_DOW      = 3'd2,
        SEL_FMT      = 3'd3,
        SEL_ALM_TIME = 3'd4,
        SEL_ALM_DATE = 3'd5,
        SEL_IRQ_EN   = 3'd6,
        SEL_FLAG_CLR = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_STEP_TIME = 2'd1,
        ST_STEP_DATE = 2'd2,
        ST_COMPARE   = 2'd3
    } step_state_e;

    // Two-digit BCD increment; the caller handles wrap limits
    function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
        if (v[3:0] == 4'd9) begin
            return {v[7:4] + 4'd1, 4'd0};
        end
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/rtc_step_fsm.sv
module rtc_step_fsm
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sec_stb,
    input  logic day_carry,
    output logic do_time,
    output logic do_date,
    output logic do_match
);

    step_state_e state_q;
    step_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sec_stb) begin
                    state_d = ST_STEP_TIME;
                end
            end
            ST_STEP_TIME: begin
                state_d = day_carry ? ST_STEP_DATE : ST_COMPARE;
            end
            ST_STEP_DATE: begin
                state_d = ST_COMPARE;
            end
            ST_COMPARE: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        do_time  = 1'b0;
        do_date  = 1'b0;
        do_match = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_STEP_TIME: do_time  = 1'b1;
            ST_STEP_DATE: do_date  = 1'b1;
            ST_COMPARE:   do_match = 1'b1;
        endcase
    end

    // A busy sequence never re-enters the time step, so late strobes are dropped
    p_busy_drop_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_STEP_TIME));

    // The date step is entered only from the time step
    p_date_after_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP_TIME) && !day_carry |=> (state_q != ST_STEP_DATE));

    // A strobe in IDLE always starts a sequence
    p_strobe_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && sec_stb |=> do_time);

endmodule

// File: rtl/rtc_time_step.sv
module rtc_time_step
    import rtc_pkg::*;
(
    input  logic [WORD_W-1:0] cur,
    input  logic              hr24,
    output logic [WORD_W-1:0] nxt,
    output logic              day_carry
);

    logic [7:0] sec, min, hr;
    logic [7:0] sec_n, min_n, hr_n;
    logic       c_min, c_hr;

    always_comb begin
        sec = cur[7:0]   & 8'h7F;
        min = cur[15:8]  & 8'h7F;
        hr  = cur[23:16] & 8'h3F;

        c_min = (sec == 8'h59);
        sec_n = c_min ? 8'h00 : bcd_inc8(sec);

        c_hr  = c_min && (min == 8'h59);
        min_n = min;
        if (c_min) begin
            min_n = c_hr ? 8'h00 : bcd_inc8(min);
        end

        hr_n      = hr;
        day_carry = 1'b0;
        if (c_hr) begin
            if (hr24) begin
                if (hr == 8'h23) begin
                    hr_n      = 8'h00;
                    day_carry = 1'b1;
                end else begin
                    hr_n = bcd_inc8(hr);
                end
            end else begin
                // 12-hour order: AM hours 01..12, PM hours 21..32
                case (hr)
                    8'h11:   hr_n = 8'h32;
                    8'h12:   hr_n = 8'h01;
                    8'h31: begin
                        hr_n      = 8'h12;
                        day_carry = 1'b1;
                    end
                    8'h32:   hr_n = 8'h21;
                    default: hr_n = bcd_inc8(hr);
                endcase
            end
        end

        nxt = {hr_n, min_n, sec_n} & TIME_MASK;
    end

endmodule

// File: rtl/rtc_date_step.sv
module rtc_date_step
    import rtc_pkg::*;
#(
    parameter int DAYS_PER_WEEK = 7,
    localparam int DOW_W = $clog2(DAYS_PER_WEEK)
) (
    input  logic [WORD_W-1:0] cur,
    input  logic [DOW_W-1:0]  dow,
    output logic [WORD_W-1:0] nxt,
    output logic [DOW_W-1:0]  nxt_dow,
    output logic              leap
);

    localparam logic [DOW_W-1:0] DOW_LAST = DOW_W'(DAYS_PER_WEEK - 1);

    logic [7:0] day, mon, yr;
    logic [7:0] day_n, mon_n, yr_n;
    logic [7:0] last_day;
    logic [1:0] mod4;

    always_comb begin
        day = cur[7:0]  & 8'h3F;
        mon = cur[15:8] & 8'h1F;
        yr  = cur[23:16];

        // (10*tens + units) mod 4 == (2*tens + units) mod 4
        mod4 = yr[1:0] + {yr[4], 1'b0};
        leap = (mod4 == 2'b00);

        case (mon)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase

        day_n = bcd_inc8(day);
        mon_n = mon;
        yr_n  = yr;
        if (day == last_day) begin
            day_n = 8'h01;
            if (mon == 8'h12) begin
                mon_n = 8'h01;
                yr_n  = (yr == 8'h99) ? 8'h00 : bcd_inc8(yr);
            end else begin
                mon_n = bcd_inc8(mon);
            end
        end

        nxt     = {yr_n, mon_n, day_n} & DATE_MASK;
        nxt_dow = (dow == DOW_LAST) ? '0 : dow + 1'b1;
    end

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int   DAYS_PER_WEEK = 7,
    parameter logic RESET_HR24    = 1'b1,
    localparam int  DOW_W         = $clog2(DAYS_PER_WEEK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_stb,
    input  logic              tick_stb,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] time_o,
    output logic [WORD_W-1:0] date_o,
    output logic [DOW_W-1:0]  dow_o,
    output logic              leap_o,
    output logic              alarm_flag_o,
    output logic              tick_flag_o,
    output logic              wake_o
);

    localparam logic [WORD_W-1:0] RESET_DATE = 24'h000101;
    localparam logic [DOW_W-1:0]  RESET_DOW  = DOW_W'(DAYS_PER_WEEK - 1);

    reg_sel_e sel;
    assign sel = reg_sel_e'(wr_sel);

    logic [WORD_W-1:0] time_q, date_q, alm_time_q, alm_date_q;
    logic [WORD_W-1:0] time_nxt, date_nxt;
    logic [DOW_W-1:0]  dow_q, dow_nxt;
    logic              hr24_q, alm_en_q, tick_en_q, wake_en_q;
    logic              alarm_flag_q, tick_flag_q, wake_q;
    logic              day_carry, leap;
    logic              do_time, do_date, do_match;
    logic              alm_hit;
    logic              wr_time, wr_date, wr_dow, wr_clr;

    assign wr_time = wr_en && (sel == SEL_TIME);
    assign wr_date = wr_en && (sel == SEL_DATE);
    assign wr_dow  = wr_en && (sel == SEL_DOW);
    assign wr_clr  = wr_en && (sel == SEL_FLAG_CLR);
    assign alm_hit = (time_q == alm_time_q) && (date_q == alm_date_q);

    rtc_step_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_stb   (sec_stb),
        .day_carry (day_carry),
        .do_time   (do_time),
        .do_date   (do_date),
        .do_match  (do_match)
    );

    rtc_time_step u_time (
        .cur       (time_q),
        .hr24      (hr24_q),
        .nxt       (time_nxt),
        .day_carry (day_carry)
    );

    rtc_date_step #(
        .DAYS_PER_WEEK (DAYS_PER_WEEK)
    ) u_date (
        .cur     (date_q),
        .dow     (dow_q),
        .nxt     (date_nxt),
        .nxt_dow (dow_nxt),
        .leap    (leap)
    );

    // Time, date and weekday: a load wins over a step in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q <= '0;
            date_q <= RESET_DATE;
            dow_q  <= RESET_DOW;
        end else begin
            if (wr_time) begin
                time_q <= wr_data & TIME_MASK;
            end else if (do_time) begin
                time_q <= time_nxt;
            end
            if (wr_date) begin
                date_q <= wr_data & DATE_MASK;
            end else if (do_date) begin
                date_q <= date_nxt;
            end
            if (wr_dow) begin
                dow_q <= wr_data[DOW_W-1:0];
            end else if (do_date) begin
                dow_q <= dow_nxt;
            end
        end
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hr24_q     <= RESET_HR24;
            alm_time_q <= '0;
            alm_date_q <= '0;
            alm_en_q   <= 1'b0;
            tick_en_q  <= 1'b0;
            wake_en_q  <= 1'b0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_FMT:      hr24_q     <= wr_data[0];
                SEL_ALM_TIME: alm_time_q <= wr_data & TIME_MASK;
                SEL_ALM_DATE: alm_date_q <= wr_data & DATE_MASK;
                SEL_IRQ_EN: begin
                    alm_en_q  <= wr_data[0];
                    tick_en_q <= wr_data[1];
                    wake_en_q <= wr_data[2];
                end
                SEL_TIME, SEL_DATE, SEL_DOW, SEL_FLAG_CLR: ;
            endcase
        end
    end

    // Flags and wake pulse: a set wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_flag_q <= 1'b0;
            tick_flag_q  <= 1'b0;
            wake_q       <= 1'b0;
        end else begin
            if (do_match && alm_en_q && alm_hit) begin
                alarm_flag_q <= 1'b1;
            end else if (wr_clr && wr_data[0]) begin
                alarm_flag_q <= 1'b0;
            end
            if (tick_stb && tick_en_q) begin
                tick_flag_q <= 1'b1;
            end else if (wr_clr && wr_data[1]) begin
                tick_flag_q <= 1'b0;
            end
            wake_q <= wake_en_q && (tick_stb || (do_match && alm_hit));
        end
    end

    assign time_o       = time_q;
    assign date_o       = date_q;
    assign dow_o        = dow_q;
    assign leap_o       = leap;
    assign alarm_flag_o = alarm_flag_q;
    assign tick_flag_o  = tick_flag_q;
    assign wake_o       = wake_q;

    // Time word moves only on a step or a load
    p_time_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !do_time && !wr_time |=> $stable(time_q));

    // A date step always moves the weekday on
    p_dow_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        do_date && !wr_dow |=> (dow_q != $past(dow_q)));

    // Matching compare with enable sets the alarm flag
    p_alarm_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        do_match && alm_en_q && alm_hit |=> alarm_flag_q);

    // Alarm flag rises only out of an enabled compare
    p_alarm_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_flag_q && !(do_match && alm_en_q) |=> !alarm_flag_q);

    // Enabled tick sets the tick flag
    p_tick_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_stb && tick_en_q |=> tick_flag_q);

    // Wake pulse requires the wake enable one cycle earlier
    p_wake_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_en_q |=> !wake_o);

endmodule

// File: tb/test_bcd_rtc_core.sv
`timescale 1ns/1ps
module test_bcd_rtc_core;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sec_stb, tick_stb, wr_en;
    logic [2:0]  wr_sel;
    logic [23:0] wr_data;
    logic [23:0] time_o, date_o;
    logic [2:0]  dow_o;
    logic        leap_o, alarm_flag_o, tick_flag_o, wake_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    bcd_rtc_core i_bcd_rtc_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .sec_stb      (sec_stb),
        .tick_stb     (tick_stb),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .time_o       (time_o),
        .date_o       (date_o),
        .dow_o        (dow_o),
        .leap_o       (leap_o),
        .alarm_flag_o (alarm_flag_o),
        .tick_flag_o  (tick_flag_o),
        .wake_o       (wake_o)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        hr24;
        logic [23:0] t_in;
        logic [23:0] d_in;
        logic [2:0]  w_in;
        logic [23:0] t_exp;
        logic [23:0] d_exp;
        logic [2:0]  w_exp;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VECS [NVEC] = '{
        '{4'd2, 1'b1, 24'h123456, 24'h240515, 3'd3, 24'h123457, 24'h240515, 3'd3}, // R2
        '{4'd2, 1'b1, 24'h105959, 24'h240515, 3'd3, 24'h110000, 24'h240515, 3'd3}, // R2
        '{4'd2, 1'b1, 24'h095959, 24'h240515, 3'd3, 24'h100000, 24'h240515, 3'd3}, // R2
        '{4'd3, 1'b1, 24'h235959, 24'h240515, 3'd3, 24'h000000, 24'h240516, 3'd4}, // R3
        '{4'd5, 1'b1, 24'h235959, 24'h230430, 3'd6, 24'h000000, 24'h230501, 3'd0}, // R5
        '{4'd5, 1'b1, 24'h235959, 24'h240228, 3'd2, 24'h000000, 24'h240229, 3'd3}, // R5
        '{4'd5, 1'b1, 24'h235959, 24'h230228, 3'd2, 24'h000000, 24'h230301, 3'd3}, // R5
        '{4'd5, 1'b1, 24'h235959, 24'h991231, 3'd5, 24'h000000, 24'h000101, 3'd6}, // R5
        '{4'd5, 1'b1, 24'h235959, 24'h240131, 3'd0, 24'h000000, 24'h240201, 3'd1}, // R5
        '{4'd5, 1'b1, 24'h235959, 24'h241130, 3'd4, 24'h000000, 24'h241201, 3'd5}, // R5
        '{4'd5, 1'b1, 24'h235959, 24'h240229, 3'd3, 24'h000000, 24'h240301, 3'd4}, // R5
        '{4'd4, 1'b0, 24'h115959, 24'h240515, 3'd3, 24'h320000, 24'h240515, 3'd3}, // R4
        '{4'd4, 1'b0, 24'h125959, 24'h240515, 3'd3, 24'h010000, 24'h240515, 3'd3}, // R4
        '{4'd4, 1'b0, 24'h325959, 24'h240515, 3'd3, 24'h210000, 24'h240515, 3'd3}, // R4
        '{4'd4, 1'b0, 24'h315959, 24'h241231, 3'd1, 24'h120000, 24'h250101, 3'd2}, // R4
        '{4'd4, 1'b0, 24'h095959, 24'h240515, 3'd3, 24'h100000, 24'h240515, 3'd3}, // R4
        '{4'd4, 1'b0, 24'h295959, 24'h240515, 3'd3, 24'h300000, 24'h240515, 3'd3}, // R4
        '{4'd6, 1'b1, 24'h235959, 24'h240515, 3'd6, 24'h000000, 24'h240516, 3'd0}  // R6
    };

    task automatic check(input string req, input string what,
                         input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [23:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic pulse_sec(input int len);
        @(negedge clk);
        sec_stb = 1'b1;
        for (int i = 0; i < len; i++) @(negedge clk);
        sec_stb = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick_stb = 1'b1;
        @(negedge clk);
        tick_stb = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        sec_stb  = 1'b0;
        tick_stb = 1'b0;
        wr_en    = 1'b0;
        wr_sel   = '0;
        wr_data  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", "time", time_o, 24'h000000);
        check("R1", "date", date_o, 24'h000101);
        check("R1", "dow", {21'd0, dow_o}, 24'd6);
        check("R1", "leap", {23'd0, leap_o}, 24'd1);
        check("R1", "alarm", {23'd0, alarm_flag_o}, 24'd0);
        check("R1", "tick", {23'd0, tick_flag_o}, 24'd0);
        check("R1", "wake", {23'd0, wake_o}, 24'd0);

        // Vector table: load, one second, compare
        for (int k = 0; k < NVEC; k++) begin
            wr(3'd3, {23'd0, VECS[k].hr24});
            wr(3'd0, VECS[k].t_in);
            wr(3'd1, VECS[k].d_in);
            wr(3'd2, {21'd0, VECS[k].w_in});
            pulse_sec(1);
            settle();
            check($sformatf("R%0d", VECS[k].req), "time", time_o, VECS[k].t_exp);
            check($sformatf("R%0d", VECS[k].req), "date", date_o, VECS[k].d_exp);
            check($sformatf("R%0d", VECS[k].req), "dow", {21'd0, dow_o}, {21'd0, VECS[k].w_exp});
        end

        // R12 masking of undefined bits
        wr(3'd0, 24'hFFFFFF);
        check("R12", "time mask", time_o, 24'h3F7F7F);
        wr(3'd1, 24'hFFFFFF);
        check("R12", "date mask", date_o, 24'hFF1F3F);

        // R7 leap indicator
        wr(3'd1, 24'h230101);
        check("R7", "leap 23", {23'd0, leap_o}, 24'd0);
        wr(3'd1, 24'h960101);
        check("R7", "leap 96", {23'd0, leap_o}, 24'd1);
        wr(3'd1, 24'h100101);
        check("R7", "leap 10", {23'd0, leap_o}, 24'd0);
        wr(3'd1, 24'h120101);
        check("R7", "leap 12", {23'd0, leap_o}, 24'd1);
        wr(3'd1, 24'h000101);
        check("R7", "leap 00", {23'd0, leap_o}, 24'd1);

        // R13 strobe held two cycles advances once
        wr(3'd3, 24'd1);
        wr(3'd0, 24'h101010);
        pulse_sec(2);
        settle();
        check("R13", "double strobe", time_o, 24'h101011);

        // R8 alarm match with wake enabled
        wr(3'd4, 24'h120001);
        wr(3'd5, 24'h240515);
        wr(3'd6, 24'h000005);
        wr(3'd0, 24'h120000);
        wr(3'd1, 24'h240515);
        pulse_sec(1);
        @(negedge clk);
        @(negedge clk);
        check("R8", "alarm set", {23'd0, alarm_flag_o}, 24'd1);
        check("R11", "wake on alarm", {23'd0, wake_o}, 24'd1);
        @(negedge clk);
        check("R11", "wake width", {23'd0, wake_o}, 24'd0);

        // R10 clear with zero bit keeps, one bit clears
        wr(3'd7, 24'h000000);
        check("R10", "no clear", {23'd0, alarm_flag_o}, 24'd1);
        wr(3'd7, 24'h000001);
        check("R10", "clear alarm", {23'd0, alarm_flag_o}, 24'd0);

        // R8 disabled alarm stays low
        wr(3'd6, 24'h000000);
        wr(3'd0, 24'h120000);
        pulse_sec(1);
        settle();
        check("R8", "alarm disabled", {23'd0, alarm_flag_o}, 24'd0);

        // R8 date mismatch stays low
        wr(3'd6, 24'h000001);
        wr(3'd0, 24'h120000);
        wr(3'd1, 24'h240516);
        pulse_sec(1);
        settle();
        check("R8", "date mismatch", {23'd0, alarm_flag_o}, 24'd0);

        // R9 tick flag
        wr(3'd6, 24'h000002);
        pulse_tick();
        check("R9", "tick set", {23'd0, tick_flag_o}, 24'd1);
        check("R11", "no wake when disabled", {23'd0, wake_o}, 24'd0);

        // R10 set wins over clear in the same cycle
        @(negedge clk);
        tick_stb = 1'b1;
        wr_en    = 1'b1;
        wr_sel   = 3'd7;
        wr_data  = 24'h000002;
        @(negedge clk);
        tick_stb = 1'b0;
        wr_en    = 1'b0;
        check("R10", "set wins", {23'd0, tick_flag_o}, 24'd1);
        wr(3'd7, 24'h000002);
        check("R10", "clear tick", {23'd0, tick_flag_o}, 24'd0);

        // R9 tick with enable off is ignored
        wr(3'd6, 24'h000000);
        pulse_tick();
        check("R9", "tick disabled", {23'd0, tick_flag_o}, 24'd0);

        // R11 wake on tick, interrupt enables off
        wr(3'd6, 24'h000004);
        pulse_tick();
        check("R11", "wake on tick", {23'd0, wake_o}, 24'd1);
        check("R9", "tick flag untouched", {23'd0, tick_flag_o}, 24'd0);
        @(negedge clk);
        check("R11", "wake drop", {23'd0, wake_o}, 24'd0);

        done = 1'b1;
        report();
        $finish;
    end

endmodule